// File: doc/BRIEF.md
# Miss-History Stride Burst Generator

This block watches a cache's miss stream and keeps a small history for each execution context: the block addresses of the two most recent misses. Each accepted miss yields two strides. The new stride runs from the previous miss to the current block. The old stride runs from the miss before that to the previous miss. When the two strides are equal, the block treats the pattern as confirmed and sends out a burst of prefetch candidates further along that stride. No instruction address is involved. The only evidence is the per-context miss history.

Each candidate leaves on a valid/ready stream as an address paired with a fixed delay. The prefetch queue downstream drains the stream at its own pace. An optional page-stop mode ends a burst at the first candidate that would leave the virtual page of the triggering block. A saturating counter records how many candidates were dropped that way. A new miss is taken only when no burst is in progress. The `busy` output tells the miss source when it may present one.

Top module: `stride_burst_gen`

## Requirements
- R1: After reset, `busy` and `pf_valid` are low and `span_count` is zero. Every history entry reads as zero, so a context's first miss sees a last and second-last address of 0.
- R2: The block aligns an accepted miss address to a block by clearing its low log2(BLK_BYTES) bits (default 6). A burst starts when (block − last) equals (last − second-last), both computed in two's complement at address width, and the degree input is non-zero.
- R3: A burst presents block + d × stride for d = 1, 2, … up to the degree captured at acceptance, in increasing d. A negative stride produces descending addresses.
- R4: Every candidate carries as its delay the latency input value captured when the miss was accepted.
- R5: Every accepted miss shifts its context's history (second-last takes last, last takes the current block). This happens even when no burst follows, including when the degree is zero or the burst is cut at a page boundary.
- R6: When context separation is off, every miss reads and updates the context-0 history whatever its context input. When it is on, each context index has its own history.
- R7: With page-stop set at acceptance, the first candidate whose bits above the page offset (log2(PAGE_BYTES), default 13) differ from those of the triggering block ends the burst. That candidate and all later ones are never presented.
- R8: When a burst is cut at step d, `span_count` rises by degree − d + 1. It saturates at its maximum and never decreases.
- R9: With page-stop clear, candidates that cross page boundaries are presented normally and `span_count` is unchanged.
- R10: While `pf_valid` is high and `pf_ready` low, the address and delay hold steady. The burst advances only on a handshake.
- R11: A miss is accepted only while `busy` is low. A miss presented while `busy` is high is ignored and leaves no trace in the history.
- R12: A miss accepted with degree zero starts no burst, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is presented |
| miss_addr | input | ADDR_W | Byte address of the miss |
| miss_ctx | input | CTX_W | Context index of the miss |
| cfg_ctx_sep | input | 1 | 1: separate history per context; 0: all misses use context 0 |
| cfg_page_stop | input | 1 | 1: end bursts at virtual-page crossings |
| cfg_degree | input | DEG_W | Number of candidates per burst |
| cfg_latency | input | DLY_W | Delay attached to each candidate |
| busy | output | 1 | A burst is in progress; misses are not accepted |
| pf_valid | output | 1 | A candidate is presented |
| pf_ready | input | 1 | The consumer takes the candidate |
| pf_addr | output | ADDR_W | Candidate address |
| pf_delay | output | DLY_W | Candidate delay |
| span_count | output | SPAN_W | Saturating count of candidates dropped at page crossings |

## Verification
The bench targets these corner cases:

- **First miss of a fresh context.** It compares against zeroed history. A design that skipped the reset value, or shared history across contexts, would fire bursts too early or too late.
- **Negative strides.** A design that handled strides unsigned would emit ascending addresses where descending ones are due.
- **Page crossings.** The bench cuts one burst at its first step and another in its middle. A wrong step index would leave an off-by-one in the dropped count. A late check would leak a cross-page address.
- **Inputs that change nothing.** A degree-zero miss and a burst truncated to nothing must still shift the history. A miss arriving during a stalled burst must be ignored entirely. A design that got either wrong would miss or invent the next confirmed stride.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    // Burst engine state
    typedef enum logic {
        BURST_IDLE = 1'b0,
        BURST_RUN  = 1'b1
    } burst_state_e;

    // Captured description of one burst
    typedef struct packed {
        logic [63:0] base;
        logic [63:0] stride;
    } burst_seed_t;

    // Largest supported context-index width
    localparam int unsigned SBG_CTX_W_MAX = 6;

endpackage

// File: rtl/sbg_history.sv
module sbg_history #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CTX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTX_W-1:0]  ctx,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_blk,
    output logic [ADDR_W-1:0] rd_last,
    output logic [ADDR_W-1:0] rd_prev
);
    localparam int unsigned CTX_N = 1 << CTX_W;

    logic [ADDR_W-1:0] last_q [CTX_N];
    logic [ADDR_W-1:0] prev_q [CTX_N];

    assign rd_last = last_q[ctx];
    assign rd_prev = prev_q[ctx];

    // Shift on every accepted miss, whether or not a burst follows
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CTX_N; i++) begin
                last_q[i] <= '0;
                prev_q[i] <= '0;
            end
        end else if (wr_en) begin
            prev_q[ctx] <= last_q[ctx];
            last_q[ctx] <= wr_blk;
        end
    end

    // R5: after a write, the entry's second-last holds the former last
    a_r5_shift : assert property (@(posedge clk) disable iff (rst)
        wr_en && !$past(rst) |=> prev_q[$past(ctx)] == $past(rd_last));

endmodule

// File: rtl/sbg_burst.sv
module sbg_burst
    import sbg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DEG_W      = 4,
    parameter int unsigned DLY_W      = 16,
    parameter int unsigned SPAN_W     = 16,
    parameter int unsigned PAGE_BYTES = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [ADDR_W-1:0] start_stride,
    input  logic [DEG_W-1:0]  start_degree,
    input  logic [DLY_W-1:0]  start_latency,
    input  logic              start_page_stop,
    input  logic              pf_ready,
    output logic              busy,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr,
    output logic [DLY_W-1:0]  pf_delay,
    output logic [SPAN_W-1:0] span_count
);
    localparam int unsigned PG_LG = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] PAGE_HI_MASK = ~ADDR_W'(PAGE_BYTES - 1);
    localparam logic [SPAN_W-1:0] SPAN_MAX = '1;

    burst_state_e      state_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] stride_q;
    logic [ADDR_W-1:0] cur_q;
    logic [DEG_W-1:0]  step_q;
    logic [DEG_W-1:0]  deg_q;
    logic [DLY_W-1:0]  lat_q;
    logic              stop_q;
    logic [SPAN_W-1:0] span_q;

    logic              running;
    logic              crossed;
    logic              last_step;
    logic [SPAN_W:0]   span_sum;
    logic [SPAN_W-1:0] span_next;

    assign running   = (state_q == BURST_RUN);
    assign crossed   = stop_q && (((cur_q ^ base_q) & PAGE_HI_MASK) != '0);
    assign last_step = (step_q == deg_q);

    // Dropped candidates: degree - step + 1, saturating
    assign span_sum  = {1'b0, span_q} + (SPAN_W+1)'(deg_q) + (SPAN_W+1)'(1)
                     - (SPAN_W+1)'(step_q);
    assign span_next = span_sum[SPAN_W] ? SPAN_MAX : span_sum[SPAN_W-1:0];

    assign busy       = running;
    assign pf_valid   = running && !crossed;
    assign pf_addr    = cur_q;
    assign pf_delay   = lat_q;
    assign span_count = span_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= BURST_IDLE;
            base_q   <= '0;
            stride_q <= '0;
            cur_q    <= '0;
            step_q   <= '0;
            deg_q    <= '0;
            lat_q    <= '0;
            stop_q   <= 1'b0;
            span_q   <= '0;
        end else if (!running) begin
            if (start) begin
                state_q  <= BURST_RUN;
                base_q   <= start_base;
                stride_q <= start_stride;
                cur_q    <= start_base + start_stride;
                step_q   <= DEG_W'(1);
                deg_q    <= start_degree;
                lat_q    <= start_latency;
                stop_q   <= start_page_stop;
            end
        end else if (crossed) begin
            state_q <= BURST_IDLE;
            span_q  <= span_next;
        end else if (pf_ready) begin
            if (last_step) begin
                state_q <= BURST_IDLE;
            end else begin
                step_q <= step_q + DEG_W'(1);
                cur_q  <= cur_q + stride_q;
            end
        end
    end

    // R10: a stalled candidate holds steady
    a_r10_hold : assert property (@(posedge clk) disable iff (rst)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr) && $stable(pf_delay));

    // R7: with page-stop, no presented address leaves the trigger's page
    a_r7_same_page : assert property (@(posedge clk) disable iff (rst)
        pf_valid && stop_q |-> pf_addr[ADDR_W-1:PG_LG] == base_q[ADDR_W-1:PG_LG]);

    // R8: the drop counter never goes down
    a_r8_span_mono : assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> span_count >= $past(span_count));

    // R11: candidates appear only inside a burst
    a_r11_valid_busy : assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> busy);

endmodule

// File: rtl/stride_burst_gen.sv
module stride_burst_gen
    import sbg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CTX_W      = 6,
    parameter int unsigned BLK_BYTES  = 64,
    parameter int unsigned PAGE_BYTES = 8192,
    parameter int unsigned DEG_W      = 4,
    parameter int unsigned DLY_W      = 16,
    parameter int unsigned SPAN_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [CTX_W-1:0]  miss_ctx,
    input  logic              cfg_ctx_sep,
    input  logic              cfg_page_stop,
    input  logic [DEG_W-1:0]  cfg_degree,
    input  logic [DLY_W-1:0]  cfg_latency,
    output logic              busy,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic [DLY_W-1:0]  pf_delay,
    output logic [SPAN_W-1:0] span_count
);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLK_BYTES - 1);

    initial begin
        if (CTX_W > SBG_CTX_W_MAX) $error("CTX_W above supported limit");
        if (SPAN_W <= DEG_W) $error("SPAN_W must exceed DEG_W");
    end

    logic [CTX_W-1:0]  ctx_sel;
    logic [ADDR_W-1:0] blk;
    logic [ADDR_W-1:0] hist_last;
    logic [ADDR_W-1:0] hist_prev;
    logic [ADDR_W-1:0] stride_new;
    logic [ADDR_W-1:0] stride_old;
    logic              accept;
    logic              launch;

    assign ctx_sel    = cfg_ctx_sep ? miss_ctx : '0;
    assign blk        = miss_addr & BLK_MASK;
    assign accept     = miss_valid && !busy;
    assign stride_new = blk - hist_last;
    assign stride_old = hist_last - hist_prev;
    assign launch     = accept && (stride_new == stride_old) && (cfg_degree != '0);

    sbg_history #(
        .ADDR_W (ADDR_W),
        .CTX_W  (CTX_W)
    ) u_hist (
        .clk     (clk),
        .rst     (rst),
        .ctx     (ctx_sel),
        .wr_en   (accept),
        .wr_blk  (blk),
        .rd_last (hist_last),
        .rd_prev (hist_prev)
    );

    sbg_burst #(
        .ADDR_W     (ADDR_W),
        .DEG_W      (DEG_W),
        .DLY_W      (DLY_W),
        .SPAN_W     (SPAN_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_burst (
        .clk             (clk),
        .rst             (rst),
        .start           (launch),
        .start_base      (blk),
        .start_stride    (stride_new),
        .start_degree    (cfg_degree),
        .start_latency   (cfg_latency),
        .start_page_stop (cfg_page_stop),
        .pf_ready        (pf_ready),
        .busy            (busy),
        .pf_valid        (pf_valid),
        .pf_addr         (pf_addr),
        .pf_delay        (pf_delay),
        .span_count      (span_count)
    );

    // R12: degree zero never raises busy
    a_r12_deg0_idle : assert property (@(posedge clk) disable iff (rst)
        miss_valid && !busy && cfg_degree == '0 |=> !busy);

    // R11: a burst only begins from an accepted miss
    a_r11_rise_from_miss : assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $rose(busy) |-> $past(miss_valid));

endmodule

// File: tb/stride_burst_gen_tb.sv
module stride_burst_gen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        miss_valid;
    logic [31:0] miss_addr;
    logic [5:0]  miss_ctx;
    logic        cfg_ctx_sep;
    logic        cfg_page_stop;
    logic [3:0]  cfg_degree;
    logic [15:0] cfg_latency;
    logic        busy;
    logic        pf_valid;
    logic        pf_ready;
    logic [31:0] pf_addr;
    logic [15:0] pf_delay;
    logic [15:0] span_count;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int exp_span = 0;

    always #10 clk = ~clk;

    stride_burst_gen u_dut (
        .clk           (clk),
        .rst           (rst),
        .miss_valid    (miss_valid),
        .miss_addr     (miss_addr),
        .miss_ctx      (miss_ctx),
        .cfg_ctx_sep   (cfg_ctx_sep),
        .cfg_page_stop (cfg_page_stop),
        .cfg_degree    (cfg_degree),
        .cfg_latency   (cfg_latency),
        .busy          (busy),
        .pf_valid      (pf_valid),
        .pf_ready      (pf_ready),
        .pf_addr       (pf_addr),
        .pf_delay      (pf_delay),
        .span_count    (span_count)
    );

    typedef struct packed {
        logic [5:0]  ctx;
        logic [31:0] addr;
        logic [3:0]  n;
        logic [31:0] stride;
        logic [3:0]  span;
    } vec_t;

    // Degree 3, page-stop on, separation on; 64-byte blocks, 8 KiB pages
    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{6'd1, 32'h0000_1000, 4'd0, 32'h0000_0000, 4'd0},
        '{6'd1, 32'h0000_1040, 4'd0, 32'h0000_0000, 4'd0},
        '{6'd1, 32'h0000_1080, 4'd3, 32'h0000_0040, 4'd0},
        '{6'd2, 32'h0000_5000, 4'd0, 32'h0000_0000, 4'd0},
        '{6'd1, 32'h0000_10C5, 4'd3, 32'h0000_0040, 4'd0},
        '{6'd2, 32'h0000_4F00, 4'd0, 32'h0000_0000, 4'd0},
        '{6'd2, 32'h0000_4E00, 4'd3, 32'hFFFF_FF00, 4'd0},
        '{6'd3, 32'h0000_1E80, 4'd0, 32'h0000_0000, 4'd0},
        '{6'd3, 32'h0000_1F00, 4'd0, 32'h0000_0000, 4'd0},
        '{6'd3, 32'h0000_1F80, 4'd0, 32'h0000_0080, 4'd3},
        '{6'd3, 32'h0000_1FC0, 4'd0, 32'h0000_0000, 4'd0},
        '{6'd4, 32'h0000_3F00, 4'd0, 32'h0000_0000, 4'd0},
        '{6'd4, 32'h0000_3F40, 4'd0, 32'h0000_0000, 4'd0},
        '{6'd4, 32'h0000_3F80, 4'd1, 32'h0000_0040, 4'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_miss(input logic [5:0] c, input logic [31:0] a);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_ctx   = c;
        miss_addr  = a;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    // Collect a burst with pf_ready high; check addresses, delays, count
    task automatic collect(input logic [31:0] a, input logic [31:0] stride,
                           input int exp_n, input string tag);
        logic [31:0] blk;
        int n;
        int guard;
        blk   = a & 32'hFFFF_FFC0;
        n     = 0;
        guard = 0;
        while (busy && guard < 100) begin
            if (pf_valid) begin
                n++;
                chk({tag, " addr"}, pf_addr, blk + 32'(n) * stride);
                chk("R4 delay", {16'h0, pf_delay}, {16'h0, cfg_latency});
            end
            guard++;
            @(negedge clk);
        end
        chk({tag, " count"}, 32'(n), 32'(exp_n));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        miss_valid = 1'b0;
        miss_addr = '0;
        miss_ctx = '0;
        cfg_ctx_sep = 1'b1;
        cfg_page_stop = 1'b1;
        cfg_degree = 4'd3;
        cfg_latency = 16'd7;
        pf_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'h0, busy}, 32'h0);
        chk("R1 pf_valid", {31'h0, pf_valid}, 32'h0);
        chk("R1 span", {16'h0, span_count}, 32'h0);

        // R2 R3 R5 R7 R8 table walk
        for (int i = 0; i < NV; i++) begin
            do_miss(TBL[i].ctx, TBL[i].addr);
            collect(TBL[i].addr, TBL[i].stride, int'(TBL[i].n), "R2 R3 R7 table");
            exp_span += int'(TBL[i].span);
            chk("R8 span", {16'h0, span_count}, 32'(exp_span));
        end

        // R10 stall and R11 ignored miss: ctx1 history is 0x1080,0x10C0
        pf_ready = 1'b0;
        do_miss(6'd1, 32'h0000_1100);
        for (int k = 0; k < 3; k++) begin
            chk("R10 hold valid", {31'h0, pf_valid}, 32'h1);
            chk("R10 hold addr", pf_addr, 32'h0000_1140);
            @(negedge clk);
        end
        miss_valid = 1'b1;
        miss_ctx   = 6'd1;
        miss_addr  = 32'h0000_9000;
        @(negedge clk);
        miss_valid = 1'b0;
        pf_ready = 1'b1;
        collect(32'h0000_1100, 32'h40, 3, "R10 drained");
        do_miss(6'd1, 32'h0000_1140);
        collect(32'h0000_1140, 32'h40, 3, "R11 busy miss ignored");

        // R6 context separation off: all misses go to context 0
        cfg_ctx_sep = 1'b0;
        do_miss(6'd7, 32'h0000_0800);
        collect(32'h0000_0800, 32'h0, 0, "R6 first");
        do_miss(6'd8, 32'h0000_0900);
        collect(32'h0000_0900, 32'h0, 0, "R6 second");
        do_miss(6'd9, 32'h0000_0A00);
        collect(32'h0000_0A00, 32'h100, 3, "R6 shared history");
        cfg_ctx_sep = 1'b1;

        // R9 page-stop clear: crossing allowed, span unchanged
        cfg_page_stop = 1'b0;
        do_miss(6'd6, 32'h0000_1E80);
        do_miss(6'd6, 32'h0000_1F00);
        do_miss(6'd6, 32'h0000_1F80);
        collect(32'h0000_1F80, 32'h80, 3, "R9 cross allowed");
        chk("R9 span", {16'h0, span_count}, 32'(exp_span));
        cfg_page_stop = 1'b1;

        // R12 degree zero, then R5 history still shifted
        cfg_degree = 4'd0;
        do_miss(6'd8, 32'h0000_0100);
        do_miss(6'd8, 32'h0000_0140);
        do_miss(6'd8, 32'h0000_0180);
        chk("R12 no burst", {31'h0, busy}, 32'h0);
        chk("R12 no valid", {31'h0, pf_valid}, 32'h0);
        cfg_degree = 4'd2;
        do_miss(6'd8, 32'h0000_01C0);
        collect(32'h0000_01C0, 32'h40, 2, "R5 shifted on degree zero");

        // R4 another latency value
        cfg_latency = 16'd300;
        do_miss(6'd8, 32'h0000_0200);
        collect(32'h0000_0200, 32'h40, 2, "R4 latency 300");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule